// File: doc/BRIEF.md
# Fused GF(3^97) Multiply / Add / Cube Operator

This block is the arithmetic core of a characteristic-three field coprocessor. It works on elements of GF(3^97), built as polynomials modulo x^97 + x^12 + 2. One datapath performs four jobs: digit-serial multiplication, signed addition, accumulation and cubing. The datapath has three partial-product generators, each scaling one operand by a single trit. Their outputs go to a three-input trit-wise adder, which feeds a result register.

A 99-trit register (R0) is loaded by the sequencer and then shifted three trits per step. Its top three trits set the scale factor of each generator for the current step. In multiplication those trits are coefficients of the multiplier. In the other modes R0 is a control word, and one load can steer up to 33 further add, accumulate or cube steps. Two operand registers (R1, R2) feed the generators. In multiply mode the reduction units multiply the operands by x, x^2 modulo the field polynomial. In cube mode a fixed folding network turns the operands into three polynomials whose sum is the cube.

The surrounding sequencer drives the loads, the shift, the mode and the step strobe each cycle, and reads the result from `p_out`.

Top module: `gf3m_fused_op`

## Requirements
- R1: A synchronous active-high reset clears R0, R1, R2 and the result register, so `p_out` reads zero after reset.
- R2: A trit is encoded as 00 for 0, 01 for 1 and 10 for 2, with trit i at bits [2i+1:2i]. Each step scales slot 2 by R0 trit 98 (bits 197:196), slot 1 by trit 97 and slot 0 by trit 96. A shift moves R0 up by three trits and fills the bottom with zero trits.
- R3: In mode 11 a step computes p ← k0·R2 + k1·(x·R1) + k2·(x^2·R2) + x^3·p. All products are reduced modulo x^97 + x^12 + 2. After a clear, 33 steps with shift yield a·b. Here a is loaded into R0 trits 0..96 with trits 97 and 98 at zero, and b is loaded into R1 and R2.
- R4: In mode 01 a step overwrites p with k0·R2 + k1·R1 + k2·R2, without any shift by x. With R1 = b, R2 = a and triple (k0, k1, k2) = (2, 1, 0), the result is b − a.
- R5: In mode 10 a step adds k0·R2 + k1·R1 + k2·R2 to the current p.
- R6: In mode 00 with a in both R1 and R2 and triple (1, 1, 1), a single step overwrites p with a^3 mod (x^97 + x^12 + 2).
- R7: With `step` low and `p_clr` low, p holds its value whatever R0 does. `p_clr` forces p to zero on the next edge and takes priority over `step`.
- R8: When `r0_ld` and `r0_shift` are both high, the load wins. Once loaded, a control word supplies successive triples to consecutive shifted steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| r0_ld | input | 1 | Load R0 from `r0_in` |
| r0_shift | input | 1 | Shift R0 up by three trits |
| r0_in | input | 198 | Multiplier operand or control word (99 trits) |
| r1_ld | input | 1 | Load R1 from `r1_in` |
| r1_in | input | 194 | Operand for R1 (97 trits) |
| r2_ld | input | 1 | Load R2 from `r2_in` |
| r2_in | input | 194 | Operand for R2 (97 trits) |
| mode | input | 2 | 00 cube, 01 add, 10 accumulate, 11 multiply |
| step | input | 1 | Update the result register this cycle |
| p_clr | input | 1 | Clear the result register |
| p_out | output | 194 | Result register |

## Verification
The hardest case to reach from the ports is reduction of high-degree terms. In multiplication these come from the top coefficients of both operands, and in cubing from operand trits above index 64, whose cubes lie above x^194 and wrap twice. Random operands hit them only loosely, so directed cases also load x^96 and all-2 polynomials into every register. A long accumulation run uses a single control word of distinct random triples. It is closed by an add step, which shows both that triples advance in order and that the add mode overwrites the accumulated sum.

// File: rtl/gf3m_pkg.sv
package gf3m_pkg;

    localparam int FM    = 97;                     // field degree
    localparam int FTAP  = 12;                     // middle exponent of x^FM + x^FTAP + 2
    localparam int NSLOT = 3;                      // trits of R0 consumed per step
    localparam int FW    = 2 * FM;                 // bits per field element
    localparam int R0T   = ((FM + NSLOT - 1) / NSLOT) * NSLOT;
    localparam int R0W   = 2 * R0T;
    localparam int NSTEP = R0T / NSLOT;

    typedef logic [1:0]    trit_t;
    typedef logic [FW-1:0] felem_t;

    typedef enum logic [1:0] {
        OP_CUBE = 2'b00,
        OP_ADD  = 2'b01,
        OP_ACC  = 2'b10,
        OP_MUL  = 2'b11
    } op_e;

    function automatic trit_t tadd(trit_t a, trit_t b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        case (s)
            3'd1, 3'd4: return 2'd1;
            3'd2:       return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

    function automatic trit_t tmul(trit_t a, trit_t b);
        if (a == 2'd0 || b == 2'd0 || a == 2'd3 || b == 2'd3) return 2'd0;
        if (a == 2'd1) return b;
        if (b == 2'd1) return a;
        return 2'd1;
    endfunction

    function automatic felem_t fadd(felem_t a, felem_t b);
        felem_t r;
        for (int i = 0; i < FM; i++) r[2*i +: 2] = tadd(a[2*i +: 2], b[2*i +: 2]);
        return r;
    endfunction

    function automatic felem_t fscale(felem_t a, trit_t k);
        felem_t r;
        for (int i = 0; i < FM; i++) r[2*i +: 2] = tmul(a[2*i +: 2], k);
        return r;
    endfunction

    // x * a mod f, using x^FM = 2*x^FTAP + 1
    function automatic felem_t fmulx(felem_t a);
        felem_t r;
        trit_t  top;
        top = a[FW-1 -: 2];
        r = {a[FW-3:0], 2'b00};
        r[1:0] = top;
        r[2*FTAP +: 2] = tadd(r[2*FTAP +: 2], tmul(top, 2'd2));
        return r;
    endfunction

    function automatic felem_t fmulx_n(felem_t a, int n);
        felem_t r;
        r = a;
        for (int i = 0; i < n; i++) r = fmulx(r);
        return r;
    endfunction

    // Coefficients base..base+FM-1 of the spread polynomial sum a_i x^(3i)
    function automatic felem_t cube_chunk(felem_t a, int base);
        felem_t r;
        r = '0;
        for (int j = 0; j < FM; j++) begin
            if ((base + j) % 3 == 0 && (base + j) / 3 < FM)
                r[2*j +: 2] = a[2*((base + j) / 3) +: 2];
        end
        return r;
    endfunction

endpackage

// File: rtl/gf3m_cube_prep.sv
module gf3m_cube_prep
    import gf3m_pkg::*;
(
    input  felem_t              r1,
    input  felem_t              r2,
    output felem_t [NSLOT-1:0]  cube_c
);
    felem_t mid, hi, mid_t, hi_t, hi_tt;

    always_comb begin
        mid   = cube_chunk(r2, FM);
        hi    = cube_chunk(r2, 2 * FM);
        mid_t = fmulx_n(mid, FTAP);
        hi_t  = fmulx_n(hi, FTAP);
        hi_tt = fmulx_n(hi_t, FTAP);
        // low third: pure wiring of R1
        cube_c[0] = cube_chunk(r1, 0);
        // middle third times x^FM = 2x^FTAP + 1
        cube_c[1] = fadd(mid, fscale(mid_t, 2'd2));
        // top third times x^(2FM) = x^(2FTAP) + x^FTAP + 1
        cube_c[2] = fadd(fadd(hi, hi_t), hi_tt);
    end
endmodule

// File: rtl/gf3m_slot_src.sv
module gf3m_slot_src
    import gf3m_pkg::*;
#(
    parameter int SLOT = 0
)(
    input  op_e    op,
    input  felem_t r1,
    input  felem_t r2,
    input  felem_t cube_c,
    output felem_t opnd
);
    localparam bit USE_R1 = (SLOT % 2) == 1;

    felem_t base;

    always_comb begin
        base = USE_R1 ? r1 : r2;
        case (op)
            OP_MUL:         opnd = fmulx_n(base, SLOT);
            OP_ADD, OP_ACC: opnd = base;
            default:        opnd = cube_c;
        endcase
    end
endmodule

// File: rtl/gf3m_ppg.sv
module gf3m_ppg
    import gf3m_pkg::*;
(
    input  trit_t  k,
    input  felem_t opnd,
    output felem_t pp
);
    always_comb pp = fscale(opnd, k);
endmodule

// File: rtl/gf3m_fused_op.sv
module gf3m_fused_op
    import gf3m_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           r0_ld,
    input  logic           r0_shift,
    input  logic [R0W-1:0] r0_in,
    input  logic           r1_ld,
    input  logic [FW-1:0]  r1_in,
    input  logic           r2_ld,
    input  logic [FW-1:0]  r2_in,
    input  logic [1:0]     mode,
    input  logic           step,
    input  logic           p_clr,
    output logic [FW-1:0]  p_out
);
    localparam int SHW = 2 * NSLOT;

    logic [R0W-1:0]     r0_q;
    felem_t             r1_q, r2_q, p_q, p_nxt, t_sum;
    felem_t [NSLOT-1:0] cube_c, opnd, pp;
    op_e                op;

    assign op = op_e'(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            r0_q <= '0;
            r1_q <= '0;
            r2_q <= '0;
        end else begin
            if (r0_ld)         r0_q <= r0_in;
            else if (r0_shift) r0_q <= {r0_q[R0W-SHW-1:0], {SHW{1'b0}}};
            if (r1_ld) r1_q <= r1_in;
            if (r2_ld) r2_q <= r2_in;
        end
    end

    gf3m_cube_prep u_cube (
        .r1     (r1_q),
        .r2     (r2_q),
        .cube_c (cube_c)
    );

    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
        gf3m_slot_src #(.SLOT(j)) u_src (
            .op     (op),
            .r1     (r1_q),
            .r2     (r2_q),
            .cube_c (cube_c[j]),
            .opnd   (opnd[j])
        );
        gf3m_ppg u_ppg (
            .k    (r0_q[2*(R0T-NSLOT+j) +: 2]),
            .opnd (opnd[j]),
            .pp   (pp[j])
        );
    end

    always_comb begin
        t_sum = '0;
        for (int j = 0; j < NSLOT; j++) t_sum = fadd(t_sum, pp[j]);
        case (op)
            OP_MUL:  p_nxt = fadd(t_sum, fmulx_n(p_q, NSLOT));
            OP_ACC:  p_nxt = fadd(t_sum, p_q);
            default: p_nxt = t_sum;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || p_clr) p_q <= '0;
        else if (step)    p_q <= p_nxt;
    end

    assign p_out = p_q;
endmodule

// File: rtl/gf3m_fused_op_chk.sv
module gf3m_fused_op_chk
    import gf3m_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           r0_ld,
    input logic           r0_shift,
    input logic           step,
    input logic           p_clr,
    input logic [R0W-1:0] r0_in,
    input logic [R0W-1:0] r0_q,
    input logic [FW-1:0]  p_q
);
    function automatic bit has_bad_trit(logic [FW-1:0] v);
        for (int i = 0; i < FM; i++) if (v[2*i +: 2] == 2'b11) return 1'b1;
        return 1'b0;
    endfunction

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (p_q == '0 && r0_q == '0));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !p_clr) |=> p_q == $past(p_q));

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        p_clr |=> p_q == '0);

    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        r0_ld |=> r0_q == $past(r0_in));

    a_r2_shift_fill: assert property (@(posedge clk) disable iff (rst)
        (r0_shift && !r0_ld) |=> r0_q == {$past(r0_q[R0W-2*NSLOT-1:0]), {(2*NSLOT){1'b0}}});

    a_r8_r0_steady: assert property (@(posedge clk) disable iff (rst)
        (!r0_shift && !r0_ld) |=> $stable(r0_q));

    a_r2_trit_codes: assert property (@(posedge clk) disable iff (rst)
        !has_bad_trit(p_q));
endmodule

bind gf3m_fused_op gf3m_fused_op_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .r0_ld    (r0_ld),
    .r0_shift (r0_shift),
    .step     (step),
    .p_clr    (p_clr),
    .r0_in    (r0_in),
    .r0_q     (r0_q),
    .p_q      (p_q)
);

// File: tb/test_gf3m_fused_op.sv
`timescale 1ns/1ps
module test_gf3m_fused_op;
    localparam int M  = 97;
    localparam int W  = 2 * M;
    localparam int RW = 198;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          r0_ld = 0, r0_shift = 0, r1_ld = 0, r2_ld = 0, step = 0, p_clr = 0;
    logic [RW-1:0] r0_in = '0;
    logic [W-1:0]  r1_in = '0, r2_in = '0;
    logic [1:0]    mode = 2'b00;
    logic [W-1:0]  p_out;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gf3m_fused_op i_gf3m_fused_op (
        .clk(clk), .rst(rst), .r0_ld(r0_ld), .r0_shift(r0_shift), .r0_in(r0_in),
        .r1_ld(r1_ld), .r1_in(r1_in), .r2_ld(r2_ld), .r2_in(r2_in),
        .mode(mode), .step(step), .p_clr(p_clr), .p_out(p_out)
    );

    function automatic int tv(logic [W-1:0] v, int i);
        return int'(v[2*i +: 2]);
    endfunction

    function automatic logic [W-1:0] m_mul(logic [W-1:0] a, logic [W-1:0] b);
        int pr[2*M-1];
        logic [W-1:0] r;
        for (int i = 0; i < 2*M-1; i++) pr[i] = 0;
        for (int i = 0; i < M; i++)
            for (int j = 0; j < M; j++) pr[i+j] += tv(a, i) * tv(b, j);
        for (int d = 2*M-2; d >= M; d--) begin
            pr[d-85] += 2 * pr[d];       // x^97 = 2x^12 + 1
            pr[d-97] += pr[d];
            pr[d] = 0;
        end
        for (int i = 0; i < M; i++) r[2*i +: 2] = 2'(pr[i] % 3);
        return r;
    endfunction

    function automatic logic [W-1:0] m_lin(int k0, int k1, int k2, logic [W-1:0] v1, logic [W-1:0] v2);
        logic [W-1:0] r;
        for (int i = 0; i < M; i++)
            r[2*i +: 2] = 2'((k0 * tv(v2, i) + k1 * tv(v1, i) + k2 * tv(v2, i)) % 3);
        return r;
    endfunction

    function automatic logic [W-1:0] m_add(logic [W-1:0] a, logic [W-1:0] b);
        return m_lin(0, 1, 1, a, b);
    endfunction

    function automatic logic [W-1:0] rnd_f();
        logic [W-1:0] r;
        for (int i = 0; i < M; i++) r[2*i +: 2] = 2'($urandom_range(2, 0));
        return r;
    endfunction

    function automatic logic [W-1:0] mono(int e, int c);
        logic [W-1:0] r = '0;
        r[2*e +: 2] = 2'(c);
        return r;
    endfunction

    function automatic logic [W-1:0] all_twos();
        logic [W-1:0] r;
        for (int i = 0; i < M; i++) r[2*i +: 2] = 2'd2;
        return r;
    endfunction

    // control word with triple s (k0,k1,k2) at trits 96-3s, 97-3s, 98-3s
    function automatic logic [RW-1:0] put_triple(logic [RW-1:0] w, int s, int k0, int k1, int k2);
        logic [RW-1:0] r = w;
        r[2*(96-3*s) +: 2] = 2'(k0);
        r[2*(97-3*s) +: 2] = 2'(k1);
        r[2*(98-3*s) +: 2] = 2'(k2);
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic load(logic [RW-1:0] w, logic [W-1:0] v1, logic [W-1:0] v2, bit clr, bit shf);
        r0_in = w; r1_in = v1; r2_in = v2;
        r0_ld = 1; r1_ld = 1; r2_ld = 1; p_clr = clr; r0_shift = shf;
        @(negedge clk);
        r0_ld = 0; r1_ld = 0; r2_ld = 0; p_clr = 0; r0_shift = 0;
    endtask

    task automatic run(logic [1:0] md, int n, bit shf);
        mode = md; step = 1; r0_shift = shf;
        repeat (n) @(negedge clk);
        step = 0; r0_shift = 0;
    endtask

    task automatic do_mul(logic [W-1:0] a, logic [W-1:0] b);
        load({4'b0, a}, b, b, 1'b1, 1'b0);
        run(2'b11, 33, 1'b1);
        check("R3 multiply", p_out, m_mul(a, b));
    endtask

    task automatic do_cube(logic [W-1:0] a);
        load(put_triple('0, 0, 1, 1, 1), a, a, 1'b0, 1'b0);
        run(2'b00, 1, 1'b0);
        check("R6 cube", p_out, m_mul(m_mul(a, a), a));
    endtask

    task automatic do_add(int k0, int k1, int k2, logic [W-1:0] v1, logic [W-1:0] v2);
        load(put_triple('0, 0, k0, k1, k2), v1, v2, 1'b0, 1'b0);
        run(2'b01, 1, 1'b0);
        check("R4 add overwrite", p_out, m_lin(k0, k1, k2, v1, v2));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a, b, acc, held;
        logic [RW-1:0] w;
        int k[7][3];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset clears result", p_out, '0);

        // R3: multiplication, directed then random
        do_mul('0, rnd_f());
        b = rnd_f(); do_mul(mono(0, 1), b);
        do_mul(mono(96, 1), mono(96, 1));
        do_mul(all_twos(), all_twos());
        do_mul(mono(96, 2), all_twos());
        for (int i = 0; i < 6; i++) do_mul(rnd_f(), rnd_f());

        // R4: signed addition, (2,1,0) gives R1 - R2
        a = rnd_f(); b = rnd_f();
        load(put_triple('0, 0, 2, 1, 0), b, a, 1'b0, 1'b0);
        run(2'b01, 1, 1'b0);
        check("R4 b minus a", m_add(p_out, a), b);
        for (int i = 0; i < 4; i++)
            do_add($urandom_range(2, 0), $urandom_range(2, 0), $urandom_range(2, 0), rnd_f(), rnd_f());

        // R6: cubing
        do_cube(mono(96, 1));
        do_cube(mono(65, 2));
        do_cube(all_twos());
        for (int i = 0; i < 5; i++) do_cube(rnd_f());

        // R5/R8: one control word drives six accumulations then an add (R4)
        a = rnd_f(); b = rnd_f(); w = '0; acc = '0;
        for (int s = 0; s < 7; s++) begin
            for (int j = 0; j < 3; j++) k[s][j] = $urandom_range(2, 0);
            w = put_triple(w, s, k[s][0], k[s][1], k[s][2]);
        end
        load(w, b, a, 1'b1, 1'b0);
        for (int s = 0; s < 6; s++) begin
            acc = m_add(acc, m_lin(k[s][0], k[s][1], k[s][2], b, a));
            run(2'b10, 1, 1'b1);
            check("R5 accumulate step", p_out, acc);
        end
        run(2'b01, 1, 1'b1);
        check("R4 add after accumulate overwrites", p_out, m_lin(k[6][0], k[6][1], k[6][2], b, a));

        // R7: hold with step low while R0 moves, then clear beats step
        do_mul(rnd_f(), rnd_f());
        held = p_out;
        mode = 2'b10;
        for (int i = 0; i < 5; i++) begin
            r0_shift = i[0];
            @(negedge clk);
        end
        r0_shift = 0;
        check("R7 hold without step", p_out, held);
        p_clr = 1; step = 1; mode = 2'b01;
        @(negedge clk);
        p_clr = 0; step = 0;
        check("R7 clear has priority", p_out, '0);

        // R8: load wins over shift in the same cycle
        a = rnd_f(); b = rnd_f();
        load(put_triple('0, 0, 1, 2, 1), b, a, 1'b0, 1'b1);
        run(2'b01, 1, 1'b0);
        check("R8 load beats shift", p_out, m_lin(1, 2, 1, b, a));

        // R2: shift fills zero trits; second step sees an all-zero triple
        load(put_triple('0, 0, 1, 1, 1), b, a, 1'b0, 1'b0);
        run(2'b01, 1, 1'b1);
        check("R2 top triple used", p_out, m_lin(1, 1, 1, b, a));
        run(2'b01, 1, 1'b1);
        check("R2 shift fills zeros", p_out, '0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule